// File: doc/BRIEF.md
# Periodic Countdown Timer with Interrupt Summary

This block is a tick-driven down-counter controlled through a single 32-bit register. The same word carries the reload value, a run enable, an interrupt enable and a write-one-to-clear acknowledge bit. While running, the counter steps down once per cycle in which `tick_i` is high. When it passes from one to zero it raises a pending flag, if interrupts are enabled, and reloads itself, so it keeps firing at a fixed period of `load` ticks.

A second, read-only word gathers interrupt sources. Five external sources come in on `src_irq_i`, and the timer's pending flag sits at bit 5. `irq_o` is the OR of that word. Software sets up the timer by writing register 0, then polls or takes interrupts, reads register 1 to find the cause, and clears the timer cause by writing 1 to bit 26.

The register port is a plain single-cycle control interface with no valid/ready: a write takes effect at the next clock edge, and the read data is combinational from `rd_addr`. No data stream enters or leaves, so no back-pressure applies.

Top module: `cdt_timer_top`

## Requirements
- R1: After reset, both readable words are zero, the counter is stopped, no interrupt is pending, and `irq_o` depends only on `src_irq_i`.
- R2: Reading address 0 returns the reload value in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. Every other bit reads 0, including the acknowledge bit 26. A write to address 1 changes nothing.
- R3: A write to address 0 while the counter is stopped loads the count with the written value. With run enabled, the 1-to-0 transition happens on exactly the `load`-th cycle in which `tick_i` is high. Cycles with `tick_i` low do not count.
- R4: While bit 24 is 0, `tick_i` has no effect: no expiry occurs, and the count is held.
- R5: At expiry the count reloads from the stored value and keeps running, so expiries repeat every `load` ticks.
- R6: A new reload value written while running leaves the current count alone and takes effect only at the next reload.
- R7: The pending flag sets at an expiry only if bit 25 is 1. An expiry with bit 25 at 0 leaves it clear.
- R8: The pending flag stays set until a write to address 0 with bit 26 at 1. A write with bit 26 at 0 does not clear it.
- R9: When an expiry and an acknowledge fall in the same cycle, the pending flag ends up set.
- R10: Address 1 reads the summary word. Bits 0 to 4 are `src_irq_i[0..4]` (playback, recording, serial audio out, game port, MIDI), bit 5 is the timer pending flag, and all higher bits are 0.
- R11: `irq_o` is 1 in the same cycle that any summary bit is 1, and 0 otherwise.
- R12: With a reload value of 0, the counter never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 timer word, 1 summary (ignored) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 timer word, 1 summary word |
| rd_data | output | 32 | Combinational read data |
| tick_i | input | 1 | Count enable pulse |
| src_irq_i | input | 5 | External interrupt sources, summary bits 4:0 |
| irq_o | output | 1 | OR of the summary word |

## Verification
The count itself has no read path, so a wrong count shows up only in when the pending bit appears. The summary word and `irq_o` rise one tick early or late, or not at all, and this becomes visible at the first expiry after the fault. Where that is a full reload period away, the effect is delayed by that many ticks. A wrong enable or pending bit shows at once in the read data of address 0 or 1 and on `irq_o`. The bench therefore counts ticks up to the expiry edge and checks the tick just before it, reads back after each write, and checks acknowledge writes that coincide with an expiry.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned CNT_W       = 20;
  localparam int unsigned RUN_BIT     = 24;
  localparam int unsigned IRQEN_BIT   = 25;
  localparam int unsigned ACK_BIT     = 26;
  localparam int unsigned N_EXT       = 5;
  localparam int unsigned TMR_SUM_BIT = 5;
  localparam int unsigned SUM_W       = 8;

  typedef enum logic {
    SEL_TIMER   = 1'b0,
    SEL_SUMMARY = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wr_load,
  input  logic             wr_run,
  input  logic             wr_irqen,
  input  logic             wr_ack,
  output logic [CNT_W-1:0] load_q,
  output logic             run_q,
  output logic             irq_en_q,
  output logic             ack_pulse,
  output logic             start_load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q   <= '0;
      run_q    <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (wr_hit) begin
      load_q   <= wr_load;
      run_q    <= wr_run;
      irq_en_q <= wr_irqen;
    end
  end

  assign ack_pulse  = wr_hit && wr_ack;
  // A write while stopped primes the count directly.
  assign start_load = wr_hit && !run_q;
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_q,
  input  logic             start_load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = tick && run_q;
  assign expire = step && (count_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start_load) begin
      count_q <= start_val;
    end else if (step) begin
      if (count_q <= ONE) count_q <= load_q;
      else                count_q <= count_q - ONE;
    end
  end
endmodule

// File: rtl/cdt_irq_summary.sv
module cdt_irq_summary
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             irq_en_q,
  input  logic             ack_pulse,
  input  logic [N_EXT-1:0] src_irq_i,
  output logic             pend_q,
  output logic [SUM_W-1:0] summary,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (expire && irq_en_q)  pend_q <= 1'b1;
    else if (ack_pulse)           pend_q <= 1'b0;
  end

  always_comb begin
    summary                 = '0;
    summary[N_EXT-1:0]      = src_irq_i;
    summary[TMR_SUM_BIT]    = pend_q;
  end

  assign irq_o = |summary;
endmodule

// File: rtl/cdt_timer_top.sv
module cdt_timer_top
  import cdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick_i,
  input  logic [N_EXT-1:0]  src_irq_i,
  output logic              irq_o
);
  logic             wr_hit;
  logic [CNT_W-1:0] load_q;
  logic             run_q;
  logic             irq_en_q;
  logic             ack_pulse;
  logic             start_load;
  logic [CNT_W-1:0] count_q;
  logic             expire;
  logic             tmr_pend;
  logic [SUM_W-1:0] summary;
  logic [DATA_W-CNT_W-3:0] wr_data_unused;

  assign wr_hit = wr_en && (reg_sel_e'(wr_addr) == SEL_TIMER);
  assign wr_data_unused = {wr_data[DATA_W-1:ACK_BIT+1], wr_data[RUN_BIT-1:CNT_W]};

  cdt_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_hit),
    .wr_load    (wr_data[CNT_W-1:0]),
    .wr_run     (wr_data[RUN_BIT]),
    .wr_irqen   (wr_data[IRQEN_BIT]),
    .wr_ack     (wr_data[ACK_BIT]),
    .load_q     (load_q),
    .run_q      (run_q),
    .irq_en_q   (irq_en_q),
    .ack_pulse  (ack_pulse),
    .start_load (start_load)
  );

  cdt_down_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_i),
    .run_q      (run_q),
    .start_load (start_load),
    .start_val  (wr_data[CNT_W-1:0]),
    .load_q     (load_q),
    .count_q    (count_q),
    .expire     (expire)
  );

  cdt_irq_summary u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .irq_en_q  (irq_en_q),
    .ack_pulse (ack_pulse),
    .src_irq_i (src_irq_i),
    .pend_q    (tmr_pend),
    .summary   (summary),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data = '0;
    if (reg_sel_e'(rd_addr) == SEL_TIMER) begin
      rd_data[CNT_W-1:0] = load_q;
      rd_data[RUN_BIT]   = run_q;
      rd_data[IRQEN_BIT] = irq_en_q;
    end else begin
      rd_data[SUM_W-1:0] = summary;
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk
  import cdt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              tick_i,
  input logic [N_EXT-1:0]  src_irq_i,
  input logic              irq_o,
  input logic              pend,
  input logic              run_q,
  input logic              irq_en_q,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  count_q
);
  logic ack_w;
  assign ack_w = wr_en && !wr_addr && wr_data[ACK_BIT];

  a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack_w) |=> pend);

  a_r7_no_set_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !irq_en_q) |=> !pend);

  a_r11_irq_is_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((|src_irq_i) || pend));

  a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && !wr_addr)) |=> $stable(count_q));

  a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run_q && count_q == CNT_W'(1)) |=> count_q == $past(load_q));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_addr |-> (rd_data[DATA_W-1:ACK_BIT] == '0 && rd_data[RUN_BIT-1:CNT_W] == '0));
endmodule

bind cdt_timer_top cdt_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .tick_i    (tick_i),
  .src_irq_i (src_irq_i),
  .irq_o     (irq_o),
  .pend      (tmr_pend),
  .run_q     (run_q),
  .irq_en_q  (irq_en_q),
  .load_q    (load_q),
  .count_q   (count_q)
);

// File: tb/test_cdt_timer_top.sv
module test_cdt_timer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        tick_i = 1'b0;
  logic [4:0]  src_irq_i = '0;
  logic        irq_o;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] q_exp[$];
  logic        q_irq[$];
  string       q_tag[$];
  event        chk_ev;

  always #10 clk = ~clk;

  cdt_timer_top i_cdt_timer_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_i(tick_i), .src_irq_i(src_irq_i), .irq_o(irq_o)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(chk_ev);
      #1;
      begin
        logic [31:0] e;
        logic        ei;
        string       t;
        e  = q_exp.pop_front();
        ei = q_irq.pop_front();
        t  = q_tag.pop_front();
        vectors++;
        if (rd_data !== e || irq_o !== ei) begin
          errors++;
          $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                   t, rd_data, irq_o, e, ei);
        end
      end
    end
  end

  task automatic drive(input logic we, input logic a, input logic [31:0] d,
                       input logic tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick_i = tk;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic wr0(input logic [31:0] d);
    drive(1'b1, 1'b0, d, 1'b0);
    idle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 32'h0, 1'b1);
    idle();
  endtask

  task automatic chk(input logic a, input logic [31:0] e, input logic ei,
                     input string tag);
    rd_addr = a;
    q_exp.push_back(e); q_irq.push_back(ei); q_tag.push_back(tag);
    -> chk_ev;
    #4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R1 reset state
    chk(1'b0, 32'h0, 1'b0, "R1 timer word after reset");
    chk(1'b1, 32'h0, 1'b0, "R1 summary after reset");

    // R10 / R11 external sources
    src_irq_i = 5'b10101;
    chk(1'b1, 32'h15, 1'b1, "R10 external bits in summary");
    src_irq_i = 5'b01000;
    chk(1'b1, 32'h08, 1'b1, "R11 irq from game port source");
    src_irq_i = 5'b0;
    chk(1'b1, 32'h0, 1'b0, "R11 irq low when summary zero");

    // R2 readback masks reserved and ack bits; address 1 write ignored
    wr0(32'hFF00_0005 & 32'h0F00_0005 | 32'h0800_0000 | 32'h0000_0000);
    chk(1'b0, 32'h0300_0005, 1'b0, "R2 timer readback fields");
    drive(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0); idle();
    chk(1'b1, 32'h0, 1'b0, "R2 write to summary ignored");
    chk(1'b0, 32'h0300_0005, 1'b0, "R2 timer word unchanged by addr1 write");

    // R3 expiry after exactly 5 ticks, idle cycles do not count
    ticks(2); idle(); idle(); ticks(2);
    chk(1'b1, 32'h0, 1'b0, "R3 no expiry after 4 ticks");
    ticks(1);
    chk(1'b1, 32'h20, 1'b1, "R3 expiry on 5th tick");

    // R8 write without ack keeps pending, with ack clears
    wr0(32'h0300_0005);
    chk(1'b1, 32'h20, 1'b1, "R8 pending held without ack bit");
    wr0(32'h0700_0005);
    chk(1'b1, 32'h0, 1'b0, "R8 ack clears pending");

    // R5 auto-reload period
    ticks(4);
    chk(1'b1, 32'h0, 1'b0, "R5 no expiry 4 ticks after reload");
    ticks(1);
    chk(1'b1, 32'h20, 1'b1, "R5 second expiry after reload");
    wr0(32'h0700_0005);

    // R6 new load while running: current period keeps old count
    wr0(32'h0300_0003);
    ticks(4);
    chk(1'b1, 32'h0, 1'b0, "R6 old count still running");
    ticks(1);
    chk(1'b1, 32'h20, 1'b1, "R6 expiry at old count");
    wr0(32'h0700_0003);
    ticks(2);
    chk(1'b1, 32'h0, 1'b0, "R6 new period not done after 2");

    // R9 ack coinciding with expiry: set wins
    drive(1'b1, 1'b0, 32'h0700_0003, 1'b1); idle();
    chk(1'b1, 32'h20, 1'b1, "R9 expiry beats same-cycle ack");

    // R7 masked interrupt
    wr0(32'h0500_0003);
    chk(1'b1, 32'h0, 1'b0, "R7 pending cleared, irq disabled");
    ticks(3);
    chk(1'b1, 32'h0, 1'b0, "R7 masked expiry leaves pending clear");

    // R4 stopped counter ignores ticks
    wr0(32'h0200_0003);
    ticks(10);
    chk(1'b1, 32'h0, 1'b0, "R4 no expiry while stopped");
    chk(1'b0, 32'h0200_0003, 1'b0, "R4 stopped readback");
    wr0(32'h0300_0002);
    ticks(1);
    chk(1'b1, 32'h0, 1'b0, "R3 restart loads new value, 1 tick");
    ticks(1);
    chk(1'b1, 32'h20, 1'b1, "R3 restart expiry after 2 ticks");

    // R12 zero reload never fires
    wr0(32'h0600_0000);
    wr0(32'h0300_0000);
    chk(1'b1, 32'h0, 1'b0, "R12 acked before zero-load run");
    ticks(30);
    chk(1'b1, 32'h0, 1'b0, "R12 zero load never expires");

    // R11 pending combined with external source
    wr0(32'h0200_0004);
    wr0(32'h0300_0004);
    ticks(4);
    src_irq_i = 5'b00010;
    chk(1'b1, 32'h22, 1'b1, "R11 pending plus recording source");
    src_irq_i = 5'b0;

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule